// File: doc/BRIEF.md
# Cartridge Program and Character Bank Mapper

This block is the bank-switching controller of a game cartridge. It watches CPU writes to the upper half of the CPU address space (0x8000-0xFFFF) and keeps four 8-bit control registers. Each register takes a whole data byte in a single write. CPU address bits 14:13 pick the register. A write whose data has bit 7 set is a mode-reset command and does not store a byte.

From the register contents, the block drives four bank numbers and a mirroring code. Two are 16K program-ROM bank numbers, one for the 0x8000 CPU window and one for the 0xC000 CPU window. Two are 4K character-memory bank numbers, one for the 0x0000 PPU window and one for the 0x1000 PPU window. All of these outputs are combinational functions of the stored registers. The static `large_mode` input selects how the program banks are formed. In large mode, bit 4 of the character register A adds an outer 256K base (0 or 16 banks), and the fixed program slot lies inside that base.

The write port is a plain control port with no valid/ready pair. A write is accepted in the cycle `wr_en` is high, and there is no back-pressure.

Top module: `cart_bank_mapper`

## Requirements
- R1: After reset, register 0 (control) holds 0x0C and the other registers hold 0. In normal mode this gives program banks 0 and PRG_BANKS16-1, character banks 0 and 1, and mirror code 00.
- R2: A write with data bit 7 set sets control bits 3 and 2 to 1. It leaves control bits 7:4 and 1:0 unchanged, and it leaves the other registers unchanged.
- R3: A write with data bit 7 clear stores the whole byte in the register chosen by address bits 14:13: 0 is control, 1 is character A, 2 is character B, 3 is program.
- R4: Writes with `wr_en` low, or with address bit 15 clear, change no register.
- R5: `mirror_mode` equals control bits 1:0. The codes are 00 single-screen lower, 01 single-screen upper, 10 vertical and 11 horizontal.
- R6: With control bit 4 = 1, `chr_bank_lo` is character A and `chr_bank_hi` is character B.
- R7: With control bit 4 = 0, one 8K bank (character A shifted right by 1) applies. `chr_bank_lo` = 2×that bank, and `chr_bank_hi` is one more.
- R8: In normal mode with control bit 3 = 0, the 32K bank is the program register shifted right by 1. `prg_bank_lo` = 2×that bank, and `prg_bank_hi` is one more.
- R9: In normal mode with control bits 3:2 = 11, `prg_bank_lo` is the program register and `prg_bank_hi` is PRG_BANKS16-1.
- R10: In normal mode with control bits 3:2 = 10, `prg_bank_lo` is 0 and `prg_bank_hi` is the program register.
- R11: In large mode, base is 16 when character A bit 4 is 1, and 0 otherwise. With control bits 3:2 = 11, the windows map to (base + program bits 3:0, base + 15). With 10, they map to (base, base + program bits 3:0).
- R12: In large mode with control bit 3 = 0, the 32K bank is (program AND (0x0F + base)) shifted right by 1. The two windows map to its two halves.
- R13: After reset in large mode, `prg_bank_lo` is 0 and `prg_bank_hi` is 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| large_mode | input | 1 | 1 selects large program-ROM mode with the outer base |
| wr_en | input | 1 | CPU write strobe |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | DW | CPU write data |
| prg_bank_lo | output | DW | 16K program bank at CPU 0x8000 |
| prg_bank_hi | output | DW | 16K program bank at CPU 0xC000 |
| chr_bank_lo | output | DW | 4K character bank at PPU 0x0000 |
| chr_bank_hi | output | DW | 4K character bank at PPU 0x1000 |
| mirror_mode | output | 2 | Nametable mirroring code |

## Verification
The assertions assume that `large_mode` is a static strap that changes only between write sequences, never together with a write. They also assume that PRG_BANKS16 fits in the data width. The stimulus changes `large_mode` only with `wr_en` low. It sweeps every value of control bits 4:0 in both modes, and it writes the program register only with data values below 0x80, so that the mode-reset command is issued on purpose, never by accident.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
  localparam int DW      = 8;
  localparam int NREG    = 4;
  localparam int SEL_W   = $clog2(NREG);
  // control register bit positions (decoded by the bank logic)
  localparam int CTL_CHR_SPLIT = 4;
  localparam int CTL_PRG_16K   = 3;
  localparam int CTL_LOW_SWAP  = 2;
  // character A bit that picks the outer program base in large mode
  localparam int OUTER_BIT     = 4;
  localparam int OUTER_BANKS   = 16;
  localparam logic [DW-1:0] CTRL_RESET = 8'h0C;
  localparam logic [DW-1:0] MODE_FORCE = 8'h0C;

  typedef enum logic [1:0] {
    MIR_ONE_LO = 2'b00,
    MIR_ONE_HI = 2'b01,
    MIR_VERT   = 2'b10,
    MIR_HORZ   = 2'b11
  } mirror_e;
endpackage

// File: rtl/mapper_regs.sv
module mapper_regs
  import mapper_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [15:0]               wr_addr,
  input  logic [DW-1:0]             wr_data,
  output logic [NREG-1:0][DW-1:0]   reg_q
);
  logic             hit;
  logic             cmd_reset;
  logic [SEL_W-1:0] sel;

  assign hit       = wr_en && wr_addr[15];
  assign cmd_reset = wr_data[DW-1];
  assign sel       = wr_addr[13 +: SEL_W];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [DW-1:0] RST_VAL = (i == 0) ? CTRL_RESET : '0;
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q <= RST_VAL;
      end else if (hit) begin
        if (cmd_reset) begin
          if (i == 0) q <= q | MODE_FORCE;
        end else if (sel == SEL_W'(i)) begin
          q <= wr_data;
        end
      end
    end
    assign reg_q[i] = q;
  end

  assert_cmd_forces_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hit && cmd_reset |=> reg_q[0][3:2] == 2'b11 &&
                         reg_q[0][7:4] == $past(reg_q[0][7:4]) &&
                         reg_q[0][1:0] == $past(reg_q[0][1:0]));

  assert_cmd_keeps_others_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hit && cmd_reset |=> $stable(reg_q[1]) && $stable(reg_q[2]) && $stable(reg_q[3]));

  assert_byte_stored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit && !cmd_reset |=> reg_q[$past(sel)] == $past(wr_data));

  assert_no_hit_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(reg_q));
endmodule

// File: rtl/mapper_prg.sv
module mapper_prg
  import mapper_pkg::*;
#(
  parameter int PRG_BANKS16 = 8
)(
  input  logic          large_mode,
  input  logic [DW-1:0] ctrl,
  input  logic [DW-1:0] chr_a,
  input  logic [DW-1:0] prg,
  output logic [DW-1:0] bank_lo,
  output logic [DW-1:0] bank_hi
);
  localparam logic [DW-1:0] LAST_BANK = DW'(PRG_BANKS16 - 1);
  localparam logic [DW-1:0] OUTER_V   = DW'(OUTER_BANKS);
  localparam logic [DW-1:0] LOW_MASK  = DW'(OUTER_BANKS - 1);

  logic [DW-1:0] base;
  logic [DW-1:0] inner;
  logic [DW-1:0] pair;

  always_comb begin
    base  = (large_mode && chr_a[OUTER_BIT]) ? OUTER_V : '0;
    inner = prg & LOW_MASK;
    pair  = large_mode ? (prg & (LOW_MASK | base)) : prg;
    if (!ctrl[CTL_PRG_16K]) begin
      bank_lo = {pair[DW-1:1], 1'b0};
      bank_hi = {pair[DW-1:1], 1'b1};
    end else if (ctrl[CTL_LOW_SWAP]) begin
      bank_lo = large_mode ? base + inner : prg;
      bank_hi = large_mode ? base + LOW_MASK : LAST_BANK;
    end else begin
      bank_lo = large_mode ? base : '0;
      bank_hi = large_mode ? base + inner : prg;
    end
  end
endmodule

// File: rtl/mapper_chr.sv
module mapper_chr
  import mapper_pkg::*;
(
  input  logic [DW-1:0] ctrl,
  input  logic [DW-1:0] chr_a,
  input  logic [DW-1:0] chr_b,
  output logic [DW-1:0] bank_lo,
  output logic [DW-1:0] bank_hi
);
  always_comb begin
    if (ctrl[CTL_CHR_SPLIT]) begin
      bank_lo = chr_a;
      bank_hi = chr_b;
    end else begin
      bank_lo = {chr_a[DW-1:1], 1'b0};
      bank_hi = {chr_a[DW-1:1], 1'b1};
    end
  end
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
  import mapper_pkg::*;
#(
  parameter int PRG_BANKS16 = 8
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          large_mode,
  input  logic          wr_en,
  input  logic [15:0]   wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] prg_bank_lo,
  output logic [DW-1:0] prg_bank_hi,
  output logic [DW-1:0] chr_bank_lo,
  output logic [DW-1:0] chr_bank_hi,
  output logic [1:0]    mirror_mode
);
  logic [NREG-1:0][DW-1:0] reg_q;
  mirror_e                 mir;

  mapper_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .reg_q   (reg_q)
  );

  mapper_prg #(.PRG_BANKS16(PRG_BANKS16)) u_prg (
    .large_mode (large_mode),
    .ctrl       (reg_q[0]),
    .chr_a      (reg_q[1]),
    .prg        (reg_q[3]),
    .bank_lo    (prg_bank_lo),
    .bank_hi    (prg_bank_hi)
  );

  mapper_chr u_chr (
    .ctrl    (reg_q[0]),
    .chr_a   (reg_q[1]),
    .chr_b   (reg_q[2]),
    .bank_lo (chr_bank_lo),
    .bank_hi (chr_bank_hi)
  );

  assign mir         = mirror_e'(reg_q[0][1:0]);
  assign mirror_mode = mir;

  assert_fixed_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !large_mode && reg_q[0][3:2] == 2'b11 |-> prg_bank_hi == DW'(PRG_BANKS16 - 1));

  assert_low_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !large_mode && reg_q[0][3:2] == 2'b10 |-> prg_bank_lo == '0);

  assert_large_fixed_R11: assert property (@(posedge clk) disable iff (!rst_n)
    large_mode && reg_q[0][3:2] == 2'b11 |-> prg_bank_hi[3:0] == 4'hF &&
                                             prg_bank_hi[4] == reg_q[1][4]);

  assert_large_32k_range_R12: assert property (@(posedge clk) disable iff (!rst_n)
    large_mode && !reg_q[0][3] |-> prg_bank_hi < DW'(2 * OUTER_BANKS) &&
                                   prg_bank_hi == prg_bank_lo + 1'b1);

  assert_chr_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_q[0][4] |-> !chr_bank_lo[0] && chr_bank_hi == chr_bank_lo + 1'b1);
endmodule

// File: tb/sim_cart_bank_mapper.sv
`timescale 1ns/1ps
module sim_cart_bank_mapper;
  localparam int LAST = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        large_mode = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  prg_bank_lo, prg_bank_hi, chr_bank_lo, chr_bank_hi;
  logic [1:0]  mirror_mode;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int m [4];
  string ctx = "R1";

  always #2 clk = ~clk;

  cart_bank_mapper u0 (
    .clk(clk), .rst_n(rst_n), .large_mode(large_mode), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .prg_bank_lo(prg_bank_lo),
    .prg_bank_hi(prg_bank_hi), .chr_bank_lo(chr_bank_lo),
    .chr_bank_hi(chr_bank_hi), .mirror_mode(mirror_mode)
  );

  task automatic cmp(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s [%s] %s: actual %0d expected %0d", req, ctx, what, act, exp);
    end
  endtask

  function automatic string prg_tag();
    if (large_mode) return (m[0] & 8) ? "R11" : "R12";
    if (!(m[0] & 8)) return "R8";
    return (m[0] & 4) ? "R9" : "R10";
  endfunction

  task automatic compare_all();
    int base, plo, phi, clo, chi;
    base = (large_mode && (m[1] & 16)) ? 16 : 0;
    if (!(m[0] & 8)) begin
      plo = large_mode ? ((m[3] & (15 + base)) >> 1) * 2 : (m[3] >> 1) * 2;
      phi = plo + 1;
    end else if (m[0] & 4) begin
      plo = large_mode ? base + (m[3] & 15) : m[3];
      phi = large_mode ? base + 15 : LAST;
    end else begin
      plo = large_mode ? base : 0;
      phi = large_mode ? base + (m[3] & 15) : m[3];
    end
    if (m[0] & 16) begin clo = m[1]; chi = m[2]; end
    else begin clo = (m[1] >> 1) * 2; chi = clo + 1; end
    cmp(prg_tag(), "prg_lo", int'(prg_bank_lo), plo);
    cmp(prg_tag(), "prg_hi", int'(prg_bank_hi), phi);
    cmp((m[0] & 16) ? "R6" : "R7", "chr_lo", int'(chr_bank_lo), clo);
    cmp((m[0] & 16) ? "R6" : "R7", "chr_hi", int'(chr_bank_hi), chi);
    cmp("R5", "mirror", int'(mirror_mode), m[0] & 3);
  endtask

  // reference compared on every clock, away from the active edge
  always @(negedge clk) if (rst_n && !done) compare_all();

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic en);
    @(negedge clk); #1;
    wr_en = en; wr_addr = a; wr_data = d;
    @(posedge clk);
    if (en && a[15]) begin
      if (d[7]) m[0] = m[0] | 12;
      else m[(a >> 13) & 3] = d;
    end
    @(negedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic do_reset(input logic lg);
    @(negedge clk); #1;
    rst_n = 1'b0; large_mode = lg;
    repeat (2) @(posedge clk);
    m[0] = 12; m[1] = 0; m[2] = 0; m[3] = 0;
    @(negedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk); #1;
  endtask

  initial begin
    int r1v [4] = '{8'h00, 8'h13, 8'h2C, 8'h7F};
    int r3v [5] = '{8'h00, 8'h05, 8'h1B, 8'h3A, 8'h7F};
    ctx = "R1";
    do_reset(1'b0);
    cmp("R1", "prg_lo", int'(prg_bank_lo), 0);
    cmp("R1", "prg_hi", int'(prg_bank_hi), LAST);
    cmp("R1", "chr_hi", int'(chr_bank_hi), 1);
    cmp("R1", "mirror", int'(mirror_mode), 0);
    ctx = "R13";
    do_reset(1'b1);
    cmp("R13", "prg_lo", int'(prg_bank_lo), 0);
    cmp("R13", "prg_hi", int'(prg_bank_hi), 15);
    do_reset(1'b0);

    ctx = "R3";
    wr(16'h8000, 8'h12, 1'b1);
    wr(16'hA000, 8'h09, 1'b1);
    wr(16'hC000, 8'h2D, 1'b1);
    wr(16'hE000, 8'h06, 1'b1);
    cmp("R3", "chr_lo", int'(chr_bank_lo), 8'h09);
    cmp("R3", "chr_hi", int'(chr_bank_hi), 8'h2D);
    cmp("R3", "prg_lo", int'(prg_bank_lo), 6);

    ctx = "R4";
    wr(16'h6000, 8'h00, 1'b1);
    wr(16'hE000, 8'h33, 1'b0);
    wr(16'h7FFF, 8'h55, 1'b1);
    cmp("R4", "prg_lo", int'(prg_bank_lo), 6);
    cmp("R4", "mirror", int'(mirror_mode), 2);

    ctx = "R2";
    wr(16'hE000, 8'h80, 1'b1);
    cmp("R2", "prg_lo", int'(prg_bank_lo), 6);
    cmp("R2", "prg_hi", int'(prg_bank_hi), LAST);
    cmp("R2", "chr_hi", int'(chr_bank_hi), 8'h2D);
    cmp("R2", "mirror", int'(mirror_mode), 2);
    wr(16'h8000, 8'h01, 1'b1);
    wr(16'hA000, 8'hFF, 1'b1);
    cmp("R2", "mirror", int'(mirror_mode), 1);
    cmp("R2", "chr_lo", int'(chr_bank_lo), 8'h08);

    for (int lg = 0; lg < 2; lg++) begin
      @(negedge clk); #1;
      large_mode = lg[0];
      for (int c = 0; c < 32; c++) begin
        ctx = "sweep";
        wr(16'h8000, 8'(c), 1'b1);
        for (int i = 0; i < 4; i++) begin
          wr(16'hA000, 8'(r1v[i]), 1'b1);
          wr(16'hC000, 8'((r1v[i] ^ 8'h35) & 8'h7F), 1'b1);
          for (int k = 0; k < 5; k++) wr(16'hE000, 8'(r3v[k]), 1'b1);
        end
      end
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule